// File: doc/BRIEF.md
# Common Interface Card Access Controller

This block sits between a host register port and two PC-card style Common Interface module slots. The host loads a 14-bit card address through two byte registers and chooses the slot and the access space (attribute memory or control/IO) in a bus-control register. A host write of the data register runs one card write strobe sequence with that byte. A host read of the data register runs one card read strobe sequence and returns the byte the card drove. While a card sequence runs, the host port reports not-ready and ignores new requests.

The bus-control register also starts a timed reset of either slot, routes the transport stream through either slot and reports whether a module is present and ready in each slot. A reset bit reads as 1 from the request until the pulse and a settle period have both passed, then clears by itself. An interrupt control register enables a level interrupt that is latched on any card-detect change and cleared by reading that register.

Top module: `ci_card_ctrl`

## Requirements
- R1: After reset, reg_ready is 1, reg_ack, irq, card_rd, card_wr, card_rst and ts_route are all 0, and the bus-control register (offset 0x7) reads 0x03 when both card_absent inputs are 1.
- R2: The address-low register (offset 0x4) stores card address bits 6..0 from written bits 7..1 and reads bit 0 as 0. The address-high register (offset 0x5) stores address bits 13..7 from written bits 6..0 and reads bit 7 as 0. card_addr shows the joined 14-bit address.
- R3: Bus-control bit 7 picks the slot: during a card strobe card_sel is 2'b01 for slot 0 and 2'b10 for slot 1, and 2'b00 outside strobes. Bus-control bit 6 drives card_space_ctl (1 = control/IO space, 0 = attribute memory).
- R4: A host write of the data register (offset 0x6) holds card_wr high for exactly CARD_CLKS cycles with card_wdata equal to the written byte; card_rd and card_wr are never high together; reg_ready is 0 while the strobe is high; reg_ack pulses for one cycle as the strobe ends.
- R5: A host read of the data register holds card_rd high for exactly CARD_CLKS cycles and returns on reg_rdata, with the reg_ack pulse, the card_rdata value of the last strobe cycle.
- R6: An access to any other register completes in one cycle: reg_ack is 1 in the cycle after the request and reg_ready stays 1.
- R7: A host request presented while reg_ready is 0 has no effect: no register changes, no ack, and the running card sequence is neither lengthened nor restarted.
- R8: Writing 1 to bus-control bit 5 (slot 0) or bit 4 (slot 1) raises card_rst of that slot for RST_CLKS cycles; the bit reads 1 for RST_CLKS + SETTLE_CLKS cycles and then reads 0. Writing 0 to it does not cancel a reset and writing 1 during a reset does not restart it.
- R9: Bus-control bit 3 drives ts_route[0] and bit 2 drives ts_route[1]; both read back.
- R10: Bus-control bit 1 reads card_absent[0] and bit 0 reads card_absent[1], each registered one clock; writes to these bits have no effect.
- R11: Writing the interrupt control register (offset 0x0) stores its bits 6 and 2; interrupts are enabled only when both are 1 (value 0x44). While enabled, any change of the registered card-detect pair sets irq, which then stays 1 until acknowledged; while disabled, detect changes leave irq at 0.
- R12: A read of the interrupt control register returns the stored enable bits in bits 6 and 2 and the pending flag in bit 0, and clears irq; a detect change in the same cycle as that read sets irq again, so the new event is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register offset of the host request |
| reg_wr | input | 1 | Host write request (wins over reg_rd) |
| reg_rd | input | 1 | Host read request |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Read result, valid with reg_ack |
| reg_ack | output | 1 | One-cycle completion pulse |
| reg_ready | output | 1 | High when a request can be accepted |
| card_addr | output | 14 | Card address |
| card_space_ctl | output | 1 | 1 = control/IO space, 0 = attribute memory |
| card_sel | output | 2 | One-hot slot select during a strobe |
| card_rd | output | 1 | Card read strobe |
| card_wr | output | 1 | Card write strobe |
| card_wdata | output | 8 | Byte driven to the card on writes |
| card_rdata | input | 8 | Byte returned by the card |
| card_rst | output | 2 | Per-slot card reset pulse |
| ts_route | output | 2 | Per-slot transport stream route enable |
| card_absent | input | 2 | Per-slot detect, 0 = module present and ready |
| irq | output | 1 | Level interrupt on card-detect change |

## Verification
The interrupt logic can receive an acknowledging read and a new card-detect change in the very same clock. The bench provokes this by changing card_absent at the same falling edge at which it presents the read of the interrupt register while an interrupt is already pending. It then checks that the read returns the old pending flag, that irq is still 1 after the acknowledge, and that a second read still reports the event before irq finally drops.

// File: rtl/ci_pkg.sv
package ci_pkg;

  localparam int CA_W = 14;

  localparam logic [3:0] OFS_INT  = 4'h0;
  localparam logic [3:0] OFS_ALO  = 4'h4;
  localparam logic [3:0] OFS_AHI  = 4'h5;
  localparam logic [3:0] OFS_DATA = 4'h6;
  localparam logic [3:0] OFS_BUS  = 4'h7;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_PULSE,
    RS_SETTLE
  } rst_phase_e;

  // Join the two address registers into the card address.
  function automatic logic [CA_W-1:0] join_addr(input logic [6:0] lo7, input logic [6:0] hi7);
    return {hi7, lo7};
  endfunction

  // Bus-control read view.
  function automatic logic [7:0] bus_view(input logic slot, input logic space,
                                          input logic [1:0] busy, input logic [1:0] ts,
                                          input logic [1:0] absent);
    return {slot, space, busy[0], busy[1], ts[0], ts[1], absent[0], absent[1]};
  endfunction

  // Interrupt control read view.
  function automatic logic [7:0] int_view(input logic en6, input logic en2, input logic pend);
    return {1'b0, en6, 3'b000, en2, 1'b0, pend};
  endfunction

  function automatic logic [1:0] slot_onehot(input logic slot);
    return slot ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/ci_card_cycle.sv
module ci_card_cycle #(
  parameter int CARD_CLKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_read,
  input  logic [7:0] wbyte,
  input  logic [7:0] card_rdata,
  output logic       busy,
  output logic       card_rd,
  output logic       card_wr,
  output logic [7:0] card_wdata,
  output logic       done,
  output logic [7:0] rbyte
);
  localparam int CNT_W = $clog2(CARD_CLKS + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      card_rd    <= 1'b0;
      card_wr    <= 1'b0;
      card_wdata <= '0;
      cnt        <= '0;
      done       <= 1'b0;
      rbyte      <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy       <= 1'b1;
        card_rd    <= is_read;
        card_wr    <= !is_read;
        card_wdata <= wbyte;
        cnt        <= CNT_W'(CARD_CLKS - 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy    <= 1'b0;
          card_rd <= 1'b0;
          card_wr <= 1'b0;
          done    <= 1'b1;
          if (card_rd) rbyte <= card_rdata;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ci_slot_reset.sv
module ci_slot_reset
  import ci_pkg::*;
#(
  parameter int RST_CLKS    = 20,
  parameter int SETTLE_CLKS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy,
  output logic card_rst
);
  localparam int MAXC = (RST_CLKS > SETTLE_CLKS) ? RST_CLKS : SETTLE_CLKS;
  localparam int RW   = $clog2(MAXC + 1);

  rst_phase_e    phase;
  logic [RW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= RS_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        RS_IDLE: if (req) begin
          phase <= RS_PULSE;
          cnt   <= RW'(RST_CLKS - 1);
        end
        RS_PULSE: if (cnt == '0) begin
          phase <= RS_SETTLE;
          cnt   <= RW'(SETTLE_CLKS - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        RS_SETTLE: if (cnt == '0) phase <= RS_IDLE;
                   else cnt <= cnt - 1'b1;
        default: phase <= RS_IDLE;
      endcase
    end
  end

  assign busy     = (phase != RS_IDLE);
  assign card_rst = (phase == RS_PULSE);
endmodule

// File: rtl/ci_irq_unit.sv
module ci_irq_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_wr,
  input  logic [1:0] en_bits,
  input  logic       ack_rd,
  input  logic [1:0] absent,
  output logic [1:0] det_q,
  output logic       en6,
  output logic       en2,
  output logic       irq_en,
  output logic       det_chg,
  output logic       pend
);
  assign irq_en  = en6 && en2;
  assign det_chg = |(absent ^ det_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q <= 2'b11;
      en6   <= 1'b0;
      en2   <= 1'b0;
      pend  <= 1'b0;
    end else begin
      det_q <= absent;
      if (en_wr) begin
        en6 <= en_bits[1];
        en2 <= en_bits[0];
      end
      if (irq_en && det_chg) pend <= 1'b1;
      else if (ack_rd)       pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ci_card_ctrl.sv
module ci_card_ctrl
  import ci_pkg::*;
#(
  parameter int CARD_CLKS   = 4,
  parameter int RST_CLKS    = 20,
  parameter int SETTLE_CLKS = 12,
  parameter int NSLOT       = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      reg_addr,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic            reg_ack,
  output logic            reg_ready,
  output logic [CA_W-1:0] card_addr,
  output logic            card_space_ctl,
  output logic [1:0]      card_sel,
  output logic            card_rd,
  output logic            card_wr,
  output logic [7:0]      card_wdata,
  input  logic [7:0]      card_rdata,
  output logic [1:0]      card_rst,
  output logic [1:0]      ts_route,
  input  logic [1:0]      card_absent,
  output logic            irq
);
  // Named internal events
  logic       accept, wr_evt, rd_evt, data_start, int_ack, int_wr, bus_wr;
  logic       cyc_busy, cyc_done;
  logic [7:0] cyc_rbyte;
  logic [1:0] rst_busy, det_q;
  logic       en6, en2, irq_en, det_chg, pend;

  logic [6:0] alo, ahi;
  logic       slot, space;
  logic [1:0] ts;
  logic       ack_q;
  logic [7:0] rdata_q, rd_mux;

  assign reg_ready  = !cyc_busy;
  assign accept     = reg_ready && (reg_wr || reg_rd);
  assign wr_evt     = accept && reg_wr;
  assign rd_evt     = accept && !reg_wr;
  assign data_start = accept && (reg_addr == OFS_DATA);
  assign int_ack    = rd_evt && (reg_addr == OFS_INT);
  assign int_wr     = wr_evt && (reg_addr == OFS_INT);
  assign bus_wr     = wr_evt && (reg_addr == OFS_BUS);

  ci_card_cycle #(.CARD_CLKS(CARD_CLKS)) u_cycle (
    .clk(clk), .rst_n(rst_n), .start(data_start), .is_read(!reg_wr),
    .wbyte(reg_wdata), .card_rdata(card_rdata), .busy(cyc_busy),
    .card_rd(card_rd), .card_wr(card_wr), .card_wdata(card_wdata),
    .done(cyc_done), .rbyte(cyc_rbyte)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    ci_slot_reset #(.RST_CLKS(RST_CLKS), .SETTLE_CLKS(SETTLE_CLKS)) u_rst (
      .clk(clk), .rst_n(rst_n), .req(bus_wr && reg_wdata[5-s]),
      .busy(rst_busy[s]), .card_rst(card_rst[s])
    );
  end

  ci_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .en_wr(int_wr), .en_bits({reg_wdata[6], reg_wdata[2]}),
    .ack_rd(int_ack), .absent(card_absent), .det_q(det_q), .en6(en6), .en2(en2),
    .irq_en(irq_en), .det_chg(det_chg), .pend(pend)
  );

  always_comb begin
    case (reg_addr)
      OFS_INT: rd_mux = int_view(en6, en2, pend);
      OFS_ALO: rd_mux = {alo, 1'b0};
      OFS_AHI: rd_mux = {1'b0, ahi};
      OFS_BUS: rd_mux = bus_view(slot, space, rst_busy, ts, det_q);
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
      alo     <= '0;
      ahi     <= '0;
      slot    <= 1'b0;
      space   <= 1'b0;
      ts      <= '0;
    end else begin
      ack_q <= accept && !data_start;
      if (rd_evt && !data_start) rdata_q <= rd_mux;
      if (wr_evt) begin
        case (reg_addr)
          OFS_ALO: alo <= reg_wdata[7:1];
          OFS_AHI: ahi <= reg_wdata[6:0];
          OFS_BUS: begin
            slot  <= reg_wdata[7];
            space <= reg_wdata[6];
            ts    <= {reg_wdata[2], reg_wdata[3]};
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_ack        = ack_q || cyc_done;
  assign reg_rdata      = cyc_done ? cyc_rbyte : rdata_q;
  assign card_addr      = join_addr(alo, ahi);
  assign card_space_ctl = space;
  assign card_sel       = (card_rd || card_wr) ? slot_onehot(slot) : 2'b00;
  assign ts_route       = ts;
  assign irq            = pend;
endmodule

// File: rtl/ci_card_ctrl_chk.sv
module ci_card_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_ready,
  input logic        card_rd,
  input logic        card_wr,
  input logic [1:0]  card_sel,
  input logic [13:0] card_addr,
  input logic [1:0]  card_rst,
  input logic [1:0]  rst_busy,
  input logic        irq,
  input logic        int_ack,
  input logic        irq_en,
  input logic        det_chg
);
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_rd && card_wr)); // R4

  AST_SEL_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (card_rd || card_wr) |-> $countones(card_sel) == 1); // R3

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (card_rd || card_wr) |-> !reg_ready); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((card_rd || card_wr) && $past(card_rd || card_wr)) |-> $stable(card_addr)); // R7

  AST_SETTLE_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_rst[0]) |-> rst_busy[0]); // R8

  AST_SETTLE_SLOT1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_rst[1]) |-> rst_busy[1]); // R8

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !int_ack) |=> irq); // R11

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !(irq_en && det_chg)) |=> !irq); // R12

  AST_CHANGE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && det_chg) |=> irq); // R12
endmodule

bind ci_card_ctrl ci_card_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_ready(reg_ready), .card_rd(card_rd),
  .card_wr(card_wr), .card_sel(card_sel), .card_addr(card_addr),
  .card_rst(card_rst), .rst_busy(rst_busy), .irq(irq), .int_ack(int_ack),
  .irq_en(irq_en), .det_chg(det_chg)
);

// File: tb/tb_ci_card_ctrl.sv
`timescale 1ns/1ps
module tb_ci_card_ctrl;
  localparam int CARD_CLKS = 4;
  localparam int RST_CLKS = 20;
  localparam int SETTLE_CLKS = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic reg_ack, reg_ready;
  logic [13:0] card_addr;
  logic card_space_ctl, card_rd, card_wr, irq;
  logic [1:0] card_sel, card_rst, ts_route;
  logic [7:0] card_wdata, card_rdata;
  logic [1:0] card_absent = 2'b11;

  always #4 clk = ~clk;

  ci_card_ctrl #(.CARD_CLKS(CARD_CLKS), .RST_CLKS(RST_CLKS), .SETTLE_CLKS(SETTLE_CLKS)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack), .reg_ready(reg_ready),
    .card_addr(card_addr), .card_space_ctl(card_space_ctl), .card_sel(card_sel),
    .card_rd(card_rd), .card_wr(card_wr), .card_wdata(card_wdata), .card_rdata(card_rdata),
    .card_rst(card_rst), .ts_route(ts_route), .card_absent(card_absent), .irq(irq)
  );

  // Card model: returned byte depends on address, space and selected slot
  function automatic logic [7:0] card_model(input logic [13:0] a, input logic sp, input logic [1:0] sel);
    logic [7:0] v;
    v = {a[3:0], a[13:10]};
    v = v ^ 8'h05;
    if (sp) v = v ^ 8'h80;
    if (sel[1]) v = v ^ 8'h40;
    if (sel[0]) v = v ^ 8'h20;
    return v;
  endfunction
  assign card_rdata = card_model(card_addr, card_space_ctl, card_sel);

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct {
    bit         cmp;
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // Monitor: pops expected completions
  always @(negedge clk) begin
    if (rst_n && reg_ack) begin
      if (sb.size() == 0) check(1'b0, "ack without request", 1, 0);
      else begin
        exp_t it;
        it = sb.pop_front();
        if (it.cmp) check(reg_rdata == it.exp, it.tag, reg_rdata, it.exp);
      end
    end
  end

  // Card strobe monitor
  int wr_len = 0, rd_len = 0, rst0_len = 0, rst1_len = 0;
  logic [7:0] last_wdata;
  logic [1:0] last_sel;
  logic last_space;
  logic [13:0] last_addr;
  always @(negedge clk) begin
    if (card_wr) begin wr_len++; last_wdata = card_wdata; end
    if (card_rd) rd_len++;
    if (card_wr || card_rd) begin last_sel = card_sel; last_space = card_space_ctl; last_addr = card_addr; end
    if (card_rst[0]) rst0_len++;
    if (card_rst[1]) rst1_len++;
  end

  task automatic host(input logic [3:0] a, input bit wr, input logic [7:0] d,
                      input bit cmp, input logic [7:0] exp, input string tag);
    exp_t it;
    it.cmp = cmp; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    reg_addr = a; reg_wr = wr; reg_rd = !wr; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    while (!reg_ready) @(negedge clk);
  endtask

  task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
    host(a, 1'b1, d, 1'b0, 8'h00, "write");
  endtask

  task automatic hread(input logic [3:0] a, input logic [7:0] exp, input string tag);
    host(a, 1'b0, 8'h00, 1'b1, exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    exp_t it;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reg_ready == 1'b1 && reg_ack == 1'b0 && irq == 1'b0, "R1 handshake/irq", {reg_ready, reg_ack, irq}, 3'b100);
    check(card_rst == 2'b00 && ts_route == 2'b00 && !card_rd && !card_wr, "R1 card outputs",
          {card_rst, ts_route, card_rd, card_wr}, 0);
    hread(4'h7, 8'h03, "R1 R10 bus-control after reset");

    // R2 address registers
    hwrite(4'h4, 8'hA5);
    hread(4'h4, 8'hA4, "R2 addr low readback");
    hwrite(4'h5, 8'hFF);
    hread(4'h5, 8'h7F, "R2 addr high readback");
    check(card_addr == 14'h3FD2, "R2 card_addr join", card_addr, 14'h3FD2);

    // R9 routing, R3 slot 0 control space
    hwrite(4'h7, 8'h48);
    check(ts_route == 2'b01, "R9 ts_route slot0", ts_route, 2'b01);
    hread(4'h7, 8'h4B, "R9 bus-control readback");

    // R4 data write
    wr_len = 0;
    hwrite(4'h6, 8'h3C);
    check(wr_len == CARD_CLKS, "R4 write strobe length", wr_len, CARD_CLKS);
    check(last_wdata == 8'h3C, "R4 write byte", last_wdata, 8'h3C);
    check(last_sel == 2'b01 && last_space == 1'b1, "R3 slot0 control space", {last_sel, last_space}, 3'b011);
    check(card_sel == 2'b00, "R3 sel idle", card_sel, 0);

    // R5 data read, slot 0 control
    rd_len = 0;
    hread(4'h6, card_model(14'h3FD2, 1'b1, 2'b01), "R5 read slot0 control");
    check(rd_len == CARD_CLKS, "R5 read strobe length", rd_len, CARD_CLKS);

    // R3/R5 slot 1 attribute memory, other address
    hwrite(4'h7, 8'h84);
    check(ts_route == 2'b10, "R9 ts_route slot1", ts_route, 2'b10);
    hwrite(4'h4, 8'h10);
    hwrite(4'h5, 8'h01);
    hread(4'h6, card_model(14'h0088, 1'b0, 2'b10), "R5 read slot1 attribute");
    check(last_sel == 2'b10 && last_space == 1'b0 && last_addr == 14'h0088, "R3 slot1 attribute",
          {last_sel, last_space, last_addr}, {2'b10, 1'b0, 14'h0088});

    // R6 single-cycle register access
    it.cmp = 1'b1; it.exp = 8'h01; it.tag = "R6 addr high data";
    sb.push_back(it);
    @(negedge clk);
    reg_addr = 4'h5; reg_rd = 1'b1;
    @(negedge clk);
    check(reg_ack == 1'b1 && reg_ready == 1'b1, "R6 one-cycle ack", {reg_ack, reg_ready}, 2'b11);
    reg_rd = 1'b0;

    // R7 request while busy is ignored
    wr_len = 0;
    it.cmp = 1'b0; it.exp = 8'h00; it.tag = "R7 data write";
    sb.push_back(it);
    @(negedge clk);
    reg_addr = 4'h6; reg_wr = 1'b1; reg_wdata = 8'h11;
    @(negedge clk);
    reg_wr = 1'b0;
    check(reg_ready == 1'b0, "R4 ready low during strobe", reg_ready, 0);
    @(negedge clk);
    reg_addr = 4'h4; reg_wr = 1'b1; reg_wdata = 8'hFE;
    @(negedge clk);
    reg_wr = 1'b0;
    while (!reg_ready) @(negedge clk);
    check(wr_len == CARD_CLKS && last_wdata == 8'h11, "R7 cycle not restarted", wr_len, CARD_CLKS);
    hread(4'h4, 8'h10, "R7 ignored write left addr low");

    // R10 detect status, R11 disabled interrupt
    card_absent = 2'b01;
    repeat (3) @(negedge clk);
    hread(4'h7, 8'h86, "R10 detect bits");
    check(irq == 1'b0, "R11 disabled no irq", irq, 0);

    // R11 enable and hold
    hwrite(4'h0, 8'h44);
    hread(4'h0, 8'h44, "R11 enable readback");
    card_absent = 2'b00;
    repeat (2) @(negedge clk);
    check(irq == 1'b1, "R11 irq raised", irq, 1);
    repeat (6) @(negedge clk);
    check(irq == 1'b1, "R11 irq held", irq, 1);
    hread(4'h0, 8'h45, "R12 pending read");
    check(irq == 1'b0, "R12 irq cleared", irq, 0);

    // R12 acknowledge colliding with a new detect change
    card_absent = 2'b10;
    repeat (2) @(negedge clk);
    check(irq == 1'b1, "R11 irq raised again", irq, 1);
    it.cmp = 1'b1; it.exp = 8'h45; it.tag = "R12 collision read";
    sb.push_back(it);
    @(negedge clk);
    reg_addr = 4'h0; reg_rd = 1'b1; card_absent = 2'b11;
    @(negedge clk);
    reg_rd = 1'b0;
    check(irq == 1'b1, "R12 event kept on collision", irq, 1);
    hread(4'h0, 8'h45, "R12 kept event reported");
    check(irq == 1'b0, "R12 irq cleared after second read", irq, 0);

    // R8 slot 0 reset
    rst0_len = 0;
    hwrite(4'h7, 8'hA4);
    hread(4'h7, 8'hA7, "R8 slot0 busy set");
    hwrite(4'h7, 8'hA4);
    hwrite(4'h7, 8'h84);
    while (card_rst[0]) @(negedge clk);
    check(rst0_len == RST_CLKS, "R8 slot0 pulse length", rst0_len, RST_CLKS);
    hread(4'h7, 8'hA7, "R8 slot0 busy in settle");
    repeat (SETTLE_CLKS + 2) @(negedge clk);
    hread(4'h7, 8'h87, "R8 slot0 busy cleared");

    // R8 slot 1 reset
    rst1_len = 0;
    hwrite(4'h7, 8'h94);
    hread(4'h7, 8'h97, "R8 slot1 busy set");
    check(card_rst[0] == 1'b0, "R8 slot0 untouched", card_rst[0], 0);
    while (card_rst[1]) @(negedge clk);
    check(rst1_len == RST_CLKS, "R8 slot1 pulse length", rst1_len, RST_CLKS);
    repeat (SETTLE_CLKS + 2) @(negedge clk);
    hread(4'h7, 8'h87, "R8 slot1 busy cleared");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "all requests acknowledged", sb.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule